// File: doc/BRIEF.md
# Prescaler-Scaler Pair Search Unit

This block picks the two divider indices for a serial timing engine. The caller supplies a required minimum division count and a mode. The block then searches two small value tables for the index pair whose product is the smallest value at or above that count. In baud mode the outer table is the baud scaler table and the inner table is the baud prescaler table. In delay mode the outer table is the delay prescaler table and the inner table is the power-of-two delay scaler table.

A one-cycle start pulse latches the mode and the count. The search then visits every combination, one multiply-compare per clock. When the sweep ends, the block registers the chosen indices and a saturation flag and raises a one-cycle done pulse. When no pair reaches the count, it returns the highest index of both tables and raises the saturation flag. The caller computes the required count beforehand as a rounded-up ratio.

Top module: `psc_search`

## Requirements
- R1: With mode_i=0 (baud), the scaler values for scl_idx_o 0..15 are 2, 4, 6, 8 and then 2^i for i=4..15, and the prescaler values for pre_idx_o 0..3 are 2, 3, 5, 7. The result is the pair with the smallest product that is at least req_i.
- R2: With mode_i=1 (delay), the prescaler values for pre_idx_o 0..3 are 1, 3, 5, 7, and the scaler value for scl_idx_o n is 2^(n+1). The result is the pair with the smallest product that is at least req_i.
- R3: The scan runs outer index then inner index in ascending order, and only the first qualifying inner entry of each outer entry is considered. A later pair with an equal product does not replace an earlier one. In baud mode, req_i=12 gives scl_idx_o=1 and pre_idx_o=1.
- R4: If no pair reaches req_i, the outputs are pre_idx_o=3, scl_idx_o=15 and sat_o=1. Otherwise sat_o=0.
- R5: req_i of 0 or 1 returns pre_idx_o=0 and scl_idx_o=0 with sat_o=0, in both modes.
- R6: done_o is high for exactly one cycle. It rises 65 clock edges after the edge that accepts start_i: 64 combinations plus one result stage.
- R7: A start_i pulse while a search is running, including its result stage, is ignored. The running search keeps its timing and its result, and no extra done_o follows.
- R8: pre_idx_o, scl_idx_o and sat_o change only together with done_o. They hold their values while req_i and mode_i change without a start.
- R9: After reset, pre_idx_o, scl_idx_o, sat_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_i | input | 1 | 0 = baud tables, 1 = delay tables |
| req_i | input | REQ_W (20) | Required minimum division count |
| pre_idx_o | output | 2 | Chosen prescaler index |
| scl_idx_o | output | SCL_W (4) | Chosen scaler index |
| sat_o | output | 1 | No pair reached the count |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that mode_i and req_i are sampled only on an accepted start, and that a second start may arrive at any time, including during the result stage. The stimulus holds start_i for exactly one cycle and changes mode_i and req_i only on falling clock edges. The random counts cover small values, mid-range values and values above both table maxima, so every check sees a mix of exact hits, round-ups and saturation. Directed cases add the tie at 12, each table maximum and one past it, a start during a busy search, and input changes with no start.

// File: rtl/psc_search_pkg.sv
package psc_search_pkg;
  typedef enum logic {
    MODE_BAUD  = 1'b0,
    MODE_DELAY = 1'b1
  } srch_mode_e;

  localparam int PRE_W  = 2;  // four prescaler entries
  localparam int PVAL_W = 3;  // prescaler values up to 7
endpackage

// File: rtl/psc_tbl.sv
module psc_tbl
  import psc_search_pkg::*;
#(
  parameter int SCL_W = 4
) (
  input  srch_mode_e                     mode_i,
  input  logic       [PRE_W-1:0]         pre_idx_i,
  input  logic       [SCL_W-1:0]         scl_idx_i,
  output logic       [PVAL_W-1:0]        pre_val_o,
  output logic       [(1<<SCL_W):0]      scl_val_o
);
  localparam int SCL_N  = 1 << SCL_W;
  localparam int SVAL_W = SCL_N + 1;

  logic [SVAL_W-1:0] baud_tbl [SCL_N];
  logic [SVAL_W-1:0] dly_tbl  [SCL_N];

  for (genvar g = 0; g < SCL_N; g++) begin : g_tbl
    if (g < 3) begin : g_lin
      assign baud_tbl[g] = SVAL_W'(2 * (g + 1));
    end else begin : g_pow
      assign baud_tbl[g] = SVAL_W'(1) << g;
    end
    assign dly_tbl[g] = SVAL_W'(1) << (g + 1);
  end

  always_comb begin
    unique case (pre_idx_i)
      2'd0:    pre_val_o = (mode_i == MODE_DELAY) ? PVAL_W'(1) : PVAL_W'(2);
      2'd1:    pre_val_o = PVAL_W'(3);
      2'd2:    pre_val_o = PVAL_W'(5);
      default: pre_val_o = PVAL_W'(7);
    endcase
  end

  assign scl_val_o = (mode_i == MODE_DELAY) ? dly_tbl[scl_idx_i] : baud_tbl[scl_idx_i];
endmodule

// File: rtl/psc_iter.sv
module psc_iter
  import psc_search_pkg::*;
#(
  parameter int SCL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  srch_mode_e       mode_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             row_first_o,
  output logic [PRE_W-1:0] pre_idx_o,
  output logic [SCL_W-1:0] scl_idx_o
);
  localparam int CNT_W = PRE_W + SCL_W;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             fin_q;
  logic             last;

  assign accept_o = start_i && !busy_q && !fin_q;
  assign step_o   = busy_q;
  assign fin_o    = fin_q;
  assign last     = busy_q && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= last;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  // baud: scaler outer, prescaler inner; delay: prescaler outer, scaler inner
  always_comb begin
    if (mode_i == MODE_DELAY) begin
      pre_idx_o   = cnt_q[CNT_W-1:SCL_W];
      scl_idx_o   = cnt_q[SCL_W-1:0];
      row_first_o = (scl_idx_o == '0);
    end else begin
      pre_idx_o   = cnt_q[PRE_W-1:0];
      scl_idx_o   = cnt_q[CNT_W-1:PRE_W];
      row_first_o = (pre_idx_o == '0);
    end
  end

  AST_ACCEPT_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_q && (cnt_q == '0)); // R6
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !last) |=> busy_q && (cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_FIN_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> fin_q && !busy_q); // R6
endmodule

// File: rtl/psc_best.sv
module psc_best
  import psc_search_pkg::*;
#(
  parameter int SCL_W = 4,
  parameter int CMP_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             row_first_i,
  input  logic [CMP_W-1:0] prod_i,
  input  logic [CMP_W-1:0] req_i,
  input  logic [PRE_W-1:0] pre_idx_i,
  input  logic [SCL_W-1:0] scl_idx_i,
  output logic             found_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [SCL_W-1:0] scl_o
);
  logic [CMP_W-1:0] best_q;
  logic             found_q;
  logic             row_hit_q;
  logic             row_hit_eff;
  logic             qual;
  logic             take;

  assign qual        = prod_i >= req_i;
  assign row_hit_eff = row_first_i ? 1'b0 : row_hit_q;
  // first qualifying entry per row only; strict less keeps earlier ties
  assign take        = step_i && qual && !row_hit_eff && (!found_q || (prod_i < best_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q    <= '0;
      found_q   <= 1'b0;
      row_hit_q <= 1'b0;
      pre_o     <= '0;
      scl_o     <= '0;
    end else if (clear_i) begin
      found_q   <= 1'b0;
      row_hit_q <= 1'b0;
    end else if (step_i) begin
      row_hit_q <= row_hit_eff | qual;
      if (take) begin
        found_q <= 1'b1;
        best_q  <= prod_i;
        pre_o   <= pre_idx_i;
        scl_o   <= scl_idx_i;
      end
    end
  end

  assign found_o = found_q;

  AST_BEST_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && found_q) |=> best_q <= $past(best_q)); // R1
  AST_BEST_MEETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_q |-> best_q >= req_i); // R1
  AST_FOUND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && found_q) |=> found_q); // R3
endmodule

// File: rtl/psc_search.sv
module psc_search
  import psc_search_pkg::*;
#(
  parameter int REQ_W = 20,
  parameter int SCL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [REQ_W-1:0] req_i,
  output logic [PRE_W-1:0] pre_idx_o,
  output logic [SCL_W-1:0] scl_idx_o,
  output logic             sat_o,
  output logic             done_o
);
  localparam int SCL_N  = 1 << SCL_W;
  localparam int SVAL_W = SCL_N + 1;
  localparam int PROD_W = SVAL_W + PVAL_W;
  localparam int CMP_W  = (REQ_W > PROD_W) ? REQ_W : PROD_W;

  srch_mode_e        mode_q;
  logic [REQ_W-1:0]  req_q;
  logic              accept, step, fin, row_first;
  logic [PRE_W-1:0]  cur_pre;
  logic [SCL_W-1:0]  cur_scl;
  logic [PVAL_W-1:0] pre_val;
  logic [SVAL_W-1:0] scl_val;
  logic [CMP_W-1:0]  prod;
  logic              found;
  logic [PRE_W-1:0]  best_pre;
  logic [SCL_W-1:0]  best_scl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_BAUD;
      req_q  <= '0;
    end else if (accept) begin
      mode_q <= srch_mode_e'(mode_i);
      req_q  <= req_i;
    end
  end

  psc_iter #(.SCL_W(SCL_W)) u_iter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_q),
    .accept_o   (accept),
    .step_o     (step),
    .fin_o      (fin),
    .row_first_o(row_first),
    .pre_idx_o  (cur_pre),
    .scl_idx_o  (cur_scl)
  );

  psc_tbl #(.SCL_W(SCL_W)) u_tbl (
    .mode_i   (mode_q),
    .pre_idx_i(cur_pre),
    .scl_idx_i(cur_scl),
    .pre_val_o(pre_val),
    .scl_val_o(scl_val)
  );

  assign prod = CMP_W'(pre_val) * CMP_W'(scl_val);

  psc_best #(.SCL_W(SCL_W), .CMP_W(CMP_W)) u_best (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (accept),
    .step_i     (step),
    .row_first_i(row_first),
    .prod_i     (prod),
    .req_i      (CMP_W'(req_q)),
    .pre_idx_i  (cur_pre),
    .scl_idx_i  (cur_scl),
    .found_o    (found),
    .pre_o      (best_pre),
    .scl_o      (best_scl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_idx_o <= '0;
      scl_idx_o <= '0;
      sat_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        pre_idx_o <= found ? best_pre : '1;
        scl_idx_o <= found ? best_scl : '1;
        sat_o     <= !found;
      end
    end
  end

  // product of the published pair, for checking only
  logic [PVAL_W-1:0] chk_pre_val;
  logic [SVAL_W-1:0] chk_scl_val;
  logic [CMP_W-1:0]  chk_prod;

  psc_tbl #(.SCL_W(SCL_W)) u_chk_tbl (
    .mode_i   (mode_q),
    .pre_idx_i(pre_idx_o),
    .scl_idx_i(scl_idx_o),
    .pre_val_o(chk_pre_val),
    .scl_val_o(chk_scl_val)
  );
  assign chk_prod = CMP_W'(chk_pre_val) * CMP_W'(chk_scl_val);

  AST_RESULT_MEETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sat_o) |-> chk_prod >= CMP_W'(req_q)); // R1
  AST_SAT_MAX_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sat_o) |-> (pre_idx_o == '1) && (scl_idx_o == '1)); // R4
  AST_SMALL_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (req_q <= REQ_W'(1))) |-> (pre_idx_o == '0) && (scl_idx_o == '0) && !sat_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pre_idx_o, scl_idx_o, sat_o}) |-> done_o); // R8
endmodule

// File: tb/psc_search_tb.sv
`timescale 1ns/1ps
module psc_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [19:0] req = '0;
  logic [1:0]  pre;
  logic [3:0]  scl;
  logic        sat;
  logic        done;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;

  always #2 clk = ~clk;

  psc_search u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .mode_i   (mode),
    .req_i    (req),
    .pre_idx_o(pre),
    .scl_idx_o(scl),
    .sat_o    (sat),
    .done_o   (done)
  );

  function automatic int bscl(int i); return (i < 3) ? 2 * (i + 1) : (1 << i); endfunction
  function automatic int bpre(int i); return (i == 0) ? 2 : (i == 1) ? 3 : (i == 2) ? 5 : 7; endfunction
  function automatic int dpre(int i); return (i == 0) ? 1 : (i == 1) ? 3 : (i == 2) ? 5 : 7; endfunction
  function automatic int dscl(int i); return 2 << i; endfunction

  task automatic model(input bit m, input int r, output int pi, output int si, output int st);
    int best;
    best = -1; pi = 3; si = 15; st = 1;
    if (!m) begin
      for (int o = 0; o < 16; o++)
        for (int i = 0; i < 4; i++) begin
          int p;
          p = bscl(o) * bpre(i);
          if (p >= r) begin
            if (best < 0 || p < best) begin best = p; si = o; pi = i; st = 0; end
            break;
          end
        end
    end else begin
      for (int o = 0; o < 4; o++)
        for (int i = 0; i < 16; i++) begin
          int p;
          p = dpre(o) * dscl(i);
          if (p >= r) begin
            if (best < 0 || p < best) begin best = p; pi = o; si = i; st = 0; end
            break;
          end
        end
    end
  endtask

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
    end
  endtask

  task automatic pulse(input bit m, input int r);
    @(negedge clk);
    start = 1'b1; mode = m; req = r[19:0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(input bit m, input int r, input string rq);
    int lat, pi, si, st;
    pulse(m, r);
    wait_done(lat);
    model(m, r, pi, si, st);
    check("R6", "latency", lat, 65);
    check(rq, "pre_idx", pre, pi);
    check(rq, "scl_idx", scl, si);
    check(rq, "sat", sat, st);
    @(negedge clk);
    check("R6", "done one cycle", done, 0);
  endtask

  initial begin
    int unsigned seed;
    int lat, pi, si, st, hits;
    logic [1:0] h_pre;
    logic [3:0] h_scl;
    logic       h_sat;
    seed = $urandom(32'd7531);
    repeat (3) @(negedge clk);
    check("R9", "reset pre", pre, 0);
    check("R9", "reset scl", scl, 0);
    check("R9", "reset sat", sat, 0);
    check("R9", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 small counts
    run(1'b0, 0, "R5");
    run(1'b0, 1, "R5");
    run(1'b1, 0, "R5");
    run(1'b1, 1, "R5");
    check("R5", "small pre", pre, 0);
    check("R5", "small scl", scl, 0);
    // R1 baud round-up and boundaries
    run(1'b0, 5, "R1");
    run(1'b0, 229376, "R1");
    check("R1", "max exact pre", pre, 3);
    check("R1", "max exact scl", scl, 15);
    // R3 tie at 12: scaler 4 x prescaler 3 wins over scaler 6 x prescaler 2
    run(1'b0, 12, "R3");
    check("R3", "tie pre", pre, 1);
    check("R3", "tie scl", scl, 1);
    // R2 delay: 100 -> 7 x 16
    run(1'b1, 100, "R2");
    check("R2", "dly pre", pre, 3);
    check("R2", "dly scl", scl, 3);
    run(1'b1, 458752, "R2");
    // R4 saturation
    run(1'b0, 229377, "R4");
    check("R4", "baud sat", sat, 1);
    run(1'b1, 458753, "R4");
    check("R4", "dly sat", sat, 1);
    check("R4", "dly sat pre", pre, 3);
    check("R4", "dly sat scl", scl, 15);

    // R7 start while busy
    pulse(1'b0, 1000);
    repeat (10) @(negedge clk);
    start = 1'b1; mode = 1'b1; req = 20'd5;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    lat = lat + 11;
    model(1'b0, 1000, pi, si, st);
    check("R7", "busy latency", lat, 65);
    check("R7", "busy pre", pre, pi);
    check("R7", "busy scl", scl, si);
    hits = 0;
    repeat (80) begin
      @(negedge clk);
      if (done) hits++;
    end
    check("R7", "extra done", hits, 0);

    // R8 hold without start
    h_pre = pre; h_scl = scl; h_sat = sat;
    mode = 1'b1; req = 20'd77777;
    repeat (20) begin
      @(negedge clk);
      req = req + 20'd13;
      mode = ~mode;
      if (done) hits++;
    end
    check("R8", "hold pre", pre, h_pre);
    check("R8", "hold scl", scl, h_scl);
    check("R8", "hold sat", sat, h_sat);
    check("R8", "no done", hits, 0);

    // random mix
    for (int k = 0; k < 60; k++) begin
      bit m;
      int r;
      m = 1'($urandom % 2);
      case ($urandom % 3)
        0:       r = int'($urandom % 64);
        1:       r = int'($urandom % 5000);
        default: r = int'($urandom % (1 << 19));
      endcase
      run(m, r, m ? "R2" : "R1");
    end

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6 watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule